// File: doc/BRIEF.md
# Fast Antenna Diversity Controller

This block chooses one of two receive antennas while a packet preamble is arriving. Once enabled, it listens on antenna A for a fixed dwell window. If no correlation sample in that window clears a programmable threshold, it flips the antenna select. It then waits out a settling gap with the receive switch open, so the external RF switch can change over, and then listens on antenna B. The block keeps alternating in this way until a sample qualifies.

The first qualifying sample locks the block onto the antenna that was listening at that moment. The lock is kept for the rest of the packet, and the block reports which antenna was chosen. A packet-end pulse, raised on completion or on abort, drops the lock and restarts the search on antenna A. The restart is immediate if A is already selected; otherwise a settling gap comes first. The default dwell is 512 cycles and the default gap is 256 cycles. At a 32 MHz reference these are 16 us and 8 us, so two dwells plus three gaps fit within four preamble symbols.

Correlation samples arrive as a valid/ready stream. The block never applies back-pressure while it is enabled: `corr_ready` follows `en`. A sample that is accepted during a settling gap or after lock is discarded. No sample is accepted while the block is disabled.

Top module: `fad_ctrl`

## Requirements
- R1: After reset, and whenever the block is disabled, the outputs are ant_a=1, ant_b=0, rx_sw=0, tx_sw=0, locked=0 and sel_ant=0.
- R2: One cycle after `en` rises, the block listens on antenna A (ant_a=1, rx_sw=1) and stays on it for DWELL_CYC cycles if no sample qualifies.
- R3: When a dwell ends with no qualifying sample, the antenna outputs swap and rx_sw stays 0 for GAP_CYC cycles. After that, rx_sw returns to 1 on the new antenna.
- R4: A sample accepted while rx_sw=0 (settling gap) never causes a lock.
- R5: A sample qualifies only when corr_valid=1 and corr_val is strictly greater than corr_thresh, compared as unsigned numbers. A value equal to the threshold does not qualify, and neither does any value with corr_valid=0.
- R6: A qualifying sample during a dwell sets locked=1 on the next cycle. It also sets sel_ant to the antenna that was listening (0 = antenna A, 1 = antenna B). The antenna outputs, sel_ant and rx_sw=1 then hold, and further samples have no effect.
- R7: With no qualifying sample, the block keeps alternating A, gap, B, gap, A, and so on indefinitely.
- R8: A pkt_end pulse while locked clears locked and sel_ant on the next cycle and restarts the search on antenna A. If antenna A was locked, the block listens again at once. If antenna B was locked, the switch to A comes first, followed by a GAP_CYC-cycle gap.
- R9: Dropping `en` returns the block to the R1 state on the next cycle. Exactly one of ant_a and ant_b is 1 at all times.
- R10: tx_sw is held at 0, since the block only serves the receive path, and corr_ready equals en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Enables the antenna search |
| corr_valid | input | 1 | Correlation sample valid |
| corr_ready | output | 1 | Sample accepted (equals en) |
| corr_val | input | CORR_W | Correlation metric, unsigned |
| corr_thresh | input | CORR_W | Lock threshold, unsigned |
| pkt_end | input | 1 | Packet complete or aborted; releases the lock |
| ant_a | output | 1 | Antenna A select |
| ant_b | output | 1 | Antenna B select |
| rx_sw | output | 1 | Receive path switch |
| tx_sw | output | 1 | Transmit path switch (held low) |
| locked | output | 1 | An antenna has been chosen |
| sel_ant | output | 1 | Chosen antenna, 0 = A, 1 = B |

## Verification
The assertions assume that pkt_end is a single-cycle pulse and that corr_val and corr_thresh are stable in any cycle where corr_valid is high. The bench changes inputs only on the falling clock edge, and each corr_valid and pkt_end pulse lasts one cycle, so every check sees settled values. The stimulus places samples inside dwell windows, inside settling gaps, exactly at the threshold, and with valid low. This covers both lock outcomes and both release paths.

// File: rtl/fad_pkg.sv
package fad_pkg;
  typedef enum logic [1:0] {
    ST_OFF    = 2'd0,
    ST_LISTEN = 2'd1,
    ST_GAP    = 2'd2,
    ST_LOCK   = 2'd3
  } fad_state_e;
endpackage

// File: rtl/fad_timer.sv
module fad_timer #(
  parameter int DWELL_CYC = 512,
  parameter int GAP_CYC   = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic in_gap,
  output logic last
);
  localparam int MAX_CYC = (DWELL_CYC > GAP_CYC) ? DWELL_CYC : GAP_CYC;
  localparam int CW      = $clog2(MAX_CYC + 1);
  localparam logic [CW-1:0] DWELL_LAST = CW'(DWELL_CYC - 1);
  localparam logic [CW-1:0] GAP_LAST   = CW'(GAP_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else          cnt <= cnt + 1'b1;
  end

  assign last = in_gap ? (cnt == GAP_LAST) : (cnt == DWELL_LAST);
endmodule

// File: rtl/fad_qualify.sv
module fad_qualify #(
  parameter int CORR_W = 8
) (
  input  logic              valid,
  input  logic [CORR_W-1:0] metric,
  input  logic [CORR_W-1:0] thresh,
  output logic              hit
);
  assign hit = valid && (metric > thresh);
endmodule

// File: rtl/fad_fsm.sv
module fad_fsm
  import fad_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       hit,
  input  logic       pkt_end,
  input  logic       phase_last,
  output fad_state_e state,
  output logic       phase_clr,
  output logic       cur_ant,
  output logic       sel_q
);
  fad_state_e state_nxt;
  logic       ant_nxt;
  logic       sel_nxt;

  always_comb begin
    state_nxt = state;
    ant_nxt   = cur_ant;
    sel_nxt   = sel_q;
    if (!en) begin
      state_nxt = ST_OFF;
      ant_nxt   = 1'b0;
      sel_nxt   = 1'b0;
    end else begin
      unique case (state)
        ST_OFF: begin
          state_nxt = ST_LISTEN;
          ant_nxt   = 1'b0;
        end
        ST_LISTEN: begin
          if (hit) begin
            state_nxt = ST_LOCK;
            sel_nxt   = cur_ant;
          end else if (phase_last) begin
            state_nxt = ST_GAP;
            ant_nxt   = ~cur_ant;
          end
        end
        ST_GAP: begin
          if (phase_last) state_nxt = ST_LISTEN;
        end
        ST_LOCK: begin
          if (pkt_end) begin
            sel_nxt = 1'b0;
            if (cur_ant) begin
              state_nxt = ST_GAP;
              ant_nxt   = 1'b0;
            end else begin
              state_nxt = ST_LISTEN;
            end
          end
        end
        default: state_nxt = ST_OFF;
      endcase
    end
  end

  assign phase_clr = (state_nxt != state);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_OFF;
      cur_ant <= 1'b0;
      sel_q   <= 1'b0;
    end else begin
      state   <= state_nxt;
      cur_ant <= ant_nxt;
      sel_q   <= sel_nxt;
    end
  end
endmodule

// File: rtl/fad_ctrl.sv
module fad_ctrl
  import fad_pkg::*;
#(
  parameter int CORR_W    = 8,
  parameter int DWELL_CYC = 512,
  parameter int GAP_CYC   = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              corr_valid,
  output logic              corr_ready,
  input  logic [CORR_W-1:0] corr_val,
  input  logic [CORR_W-1:0] corr_thresh,
  input  logic              pkt_end,
  output logic              ant_a,
  output logic              ant_b,
  output logic              rx_sw,
  output logic              tx_sw,
  output logic              locked,
  output logic              sel_ant
);
  fad_state_e state;
  logic       hit;
  logic       phase_last;
  logic       phase_clr;
  logic       cur_ant;
  logic       sel_q;

  fad_qualify #(.CORR_W(CORR_W)) u_qual (
    .valid  (corr_valid),
    .metric (corr_val),
    .thresh (corr_thresh),
    .hit    (hit)
  );

  fad_timer #(.DWELL_CYC(DWELL_CYC), .GAP_CYC(GAP_CYC)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (phase_clr),
    .in_gap (state == ST_GAP),
    .last   (phase_last)
  );

  fad_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .hit        (hit),
    .pkt_end    (pkt_end),
    .phase_last (phase_last),
    .state      (state),
    .phase_clr  (phase_clr),
    .cur_ant    (cur_ant),
    .sel_q      (sel_q)
  );

  assign corr_ready = en;
  assign ant_a      = ~cur_ant;
  assign ant_b      = cur_ant;
  assign rx_sw      = (state == ST_LISTEN) || (state == ST_LOCK);
  assign tx_sw      = 1'b0;
  assign locked     = (state == ST_LOCK);
  assign sel_ant    = sel_q;
endmodule

// File: rtl/fad_ctrl_chk.sv
module fad_ctrl_chk #(
  parameter int CORR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              corr_valid,
  input logic [CORR_W-1:0] corr_val,
  input logic [CORR_W-1:0] corr_thresh,
  input logic              pkt_end,
  input logic              ant_a,
  input logic              ant_b,
  input logic              rx_sw,
  input logic              locked,
  input logic              sel_ant
);
  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (ant_a && !ant_b && !rx_sw && !locked && !sel_ant)); // R9

  AST_SWAP_OPENS_RX: assert property (@(posedge clk) disable iff (!rst_n)
    (ant_b != $past(ant_b)) |-> !rx_sw); // R3

  AST_GAP_NO_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_sw |=> !$rose(locked)); // R4

  AST_LOCK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(corr_valid && (corr_val > corr_thresh))); // R5

  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && en && !pkt_end) |=> (locked && $stable(sel_ant) && $stable(ant_b) && rx_sw)); // R6

  AST_SEL_IS_ANT: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> (sel_ant == ant_b)); // R6

  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && pkt_end) |=> (!locked && !sel_ant && ant_a)); // R8
endmodule

bind fad_ctrl fad_ctrl_chk #(.CORR_W(CORR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .corr_valid(corr_valid),
  .corr_val(corr_val), .corr_thresh(corr_thresh), .pkt_end(pkt_end),
  .ant_a(ant_a), .ant_b(ant_b), .rx_sw(rx_sw), .locked(locked),
  .sel_ant(sel_ant)
);

// File: tb/fad_ctrl_test.sv
`timescale 1ns/1ps
module fad_ctrl_test;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic corr_valid = 1'b0;
  logic [CW-1:0] corr_val = '0;
  logic [CW-1:0] corr_thresh = 8'd100;
  logic pkt_end = 1'b0;
  logic corr_ready, ant_a, ant_b, rx_sw, tx_sw, locked, sel_ant;

  int total = 0;
  int bad = 0;
  int slot = 0;
  logic prev_locked = 1'b0;

  typedef struct { logic ant; int at; } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  fad_ctrl #(.CORR_W(CW), .DWELL_CYC(512), .GAP_CYC(256)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .corr_valid(corr_valid),
    .corr_ready(corr_ready), .corr_val(corr_val), .corr_thresh(corr_thresh),
    .pkt_end(pkt_end), .ant_a(ant_a), .ant_b(ant_b), .rx_sw(rx_sw),
    .tx_sw(tx_sw), .locked(locked), .sel_ant(sel_ant)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s slot=%0d actual=%0d expected=%0d", req, slot, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    slot++;
  endtask

  task automatic goto(input int k);
    while (slot < k) tick();
  endtask

  task automatic state_chk(input string req, input int a, input int rx, input int lk, input int sel);
    chk(ant_a === a[0] && ant_b === ~a[0], req, {ant_a, ant_b}, {a[0], ~a[0]});
    chk(rx_sw === rx[0], req, rx_sw, rx);
    chk(locked === lk[0] && sel_ant === sel[0], req, {locked, sel_ant}, {lk[0], sel[0]});
  endtask

  // driver: applies one sample in the current slot; pushes expected lock
  task automatic sample(input int v, input logic vld, input logic expect_lock, input logic ant);
    corr_val = v[CW-1:0];
    corr_valid = vld;
    if (expect_lock) q.push_back('{ant: ant, at: slot});
    tick();
    corr_valid = 1'b0;
    corr_val = '0;
  endtask

  task automatic start();
    en = 1'b1;
    slot = 0;
  endtask

  // monitor: compares every new lock against the scoreboard queue
  always @(posedge clk) begin
    #2;
    if (rst_n && locked && !prev_locked) begin
      if (q.size() == 0) begin
        chk(1'b0, "R6 unexpected lock", slot, -1);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(sel_ant === e.ant, "R6 selected antenna", sel_ant, e.ant);
        chk(slot == e.at, "R6 lock timing", slot, e.at);
      end
    end
    prev_locked = locked;
  end

  initial begin
    #(200000 * 10);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    state_chk("R1 reset", 1, 0, 0, 0);
    chk(tx_sw === 1'b0 && corr_ready === 1'b0, "R10 reset", {tx_sw, corr_ready}, 0);
    rst_n = 1'b1;
    tick();
    state_chk("R1 after reset", 1, 0, 0, 0);

    start();
    tick();
    state_chk("R2 listen A", 1, 1, 0, 0);
    chk(corr_ready === 1'b1 && tx_sw === 1'b0, "R10 enabled", {tx_sw, corr_ready}, 1);
    goto(512);
    state_chk("R2 dwell end", 1, 1, 0, 0);
    tick();
    state_chk("R3 gap to B", 0, 0, 0, 0);
    goto(600);
    sample(200, 1'b1, 1'b0, 1'b0);
    state_chk("R4 gap sample ignored", 0, 0, 0, 0);
    goto(768);
    state_chk("R3 gap last", 0, 0, 0, 0);
    tick();
    state_chk("R3 listen B", 0, 1, 0, 0);
    goto(800);
    sample(100, 1'b1, 1'b0, 1'b0);
    state_chk("R5 equal threshold", 0, 1, 0, 0);
    sample(255, 1'b0, 1'b0, 1'b0);
    state_chk("R5 valid low", 0, 1, 0, 0);
    goto(900);
    sample(101, 1'b1, 1'b1, 1'b1);
    state_chk("R6 lock on B", 0, 1, 1, 1);
    sample(0, 1'b1, 1'b0, 1'b0);
    goto(1500);
    state_chk("R6 lock held", 0, 1, 1, 1);
    goto(1600);
    pkt_end = 1'b1;
    tick();
    pkt_end = 1'b0;
    state_chk("R8 release from B", 1, 0, 0, 0);
    goto(1856);
    state_chk("R8 gap after release", 1, 0, 0, 0);
    tick();
    state_chk("R8 listen A again", 1, 1, 0, 0);
    en = 1'b0;
    tick();
    state_chk("R9 disable", 1, 0, 0, 0);

    start();
    goto(1537);
    state_chk("R7 back to A", 1, 1, 0, 0);
    goto(2305);
    state_chk("R7 B again", 0, 1, 0, 0);
    goto(3073);
    state_chk("R7 A third", 1, 1, 0, 0);
    goto(3100);
    sample(250, 1'b1, 1'b1, 1'b0);
    state_chk("R6 lock on A", 1, 1, 1, 0);
    goto(3200);
    pkt_end = 1'b1;
    tick();
    pkt_end = 1'b0;
    state_chk("R8 release from A", 1, 1, 0, 0);
    en = 1'b0;
    tick();
    state_chk("R9 disable again", 1, 0, 0, 0);
    tick();
    chk(q.size() == 0, "R6 all locks seen", q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule